// File: doc/BRIEF.md
# Configurable Cell Header Error Filter

This block sits on a receive byte stream of fixed-length 53-byte cells. Each cell opens with a five-byte header whose last byte is a check byte protecting the four bytes before it. The block recomputes that check byte, compares it with the received one, and then applies one of four policies chosen by a two-bit mode input. Depending on the policy, the cell is passed untouched, repaired, or removed from the stream. A saturating counter records every header that the policy treats as bad.

The block holds every byte in a five-stage delay line. The verdict for a cell is therefore settled before that cell's first byte reaches the output. A discarded cell produces no output bytes at all, only a one-cycle discard pulse. An accepted cell leaves with a freshly computed check byte, except in the pass-through policy.

The input side is a state machine with states IN_IDLE, IN_HDR and IN_PAY. A start marker moves it from any state into IN_HDR. In IN_HDR, the fifth byte moves it to IN_PAY. In IN_PAY, byte 53 moves it back to IN_IDLE. The output side is a state machine with states OUT_IDLE, OUT_HDR, OUT_PAY and OUT_SKIP. A start marker at the tail of the delay line moves it to OUT_HDR if the cell is kept, or to OUT_SKIP if it is dropped. OUT_HDR moves to OUT_PAY after the fifth byte. OUT_PAY and OUT_SKIP both return to OUT_IDLE after byte 53.

Top module: `cell_hec_filter`

## Requirements
- R1: While reset is asserted, and directly after it, out_valid is 0 and bad_hec_count is 0.
- R2: The check byte is the remainder of the 32 header bits, taken first byte first and MSB first, multiplied by x^8 and divided by x^8+x^2+x+1, then XORed with 0x55. An all-zero header has check byte 0x55. In modes 01, 10 and 11, an accepted cell leaves with the check byte recomputed from the header bytes it leaves with.
- R3: Kept cells leave in input order with the same byte count and unchanged payload bytes, and out_sop is set on the first byte only. Idle cycles between payload bytes do not alter the output sequence. The five header bytes must arrive on consecutive cycles.
- R4: In mode 00, every cell leaves exactly as received, including its original check byte, and the counter does not move.
- R5: In mode 01, a single flipped bit anywhere in the 40 header bits is repaired. The cell is kept and the counter does not move.
- R6: In mode 01, an error that cannot be repaired (for example, two flipped bits) keeps the cell. The four header bytes leave as received with a recomputed check byte, and the counter increments by one.
- R7: In mode 10, any check-byte mismatch, even a single bit, discards the cell and increments the counter once. A matching cell is kept.
- R8: In mode 11, a single flipped bit is repaired without counting. An error that cannot be repaired discards the cell and increments the counter.
- R9: A discarded cell emits no byte. drop_pulse is high for exactly one cycle per discarded cell, and never in a cycle where out_valid is high.
- R10: bad_hec_count steps by at most one per cycle, never decreases, and stays at its maximum (all ones) once reached.
- R11: Valid bytes that arrive while no cell is open, that is, before any start marker or after byte 53, are not emitted.
- R12: The mode is sampled in the cycle the check byte arrives. Mode values on other bytes of the cell have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| in_mode | input | 2 | Policy: 00 pass, 01 repair and keep, 10 strict drop, 11 repair or drop |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | Output byte is the first byte of a cell |
| out_data | output | 8 | Output byte |
| drop_pulse | output | 1 | One-cycle pulse for each discarded cell |
| bad_hec_count | output | CNT_W | Saturating count of bad headers |

## Verification
The bench sends cells in four forms under each mode: clean headers, a single flipped bit in the header, a single flipped bit in the check byte, and two flipped bits. Single-bit errors separate repair from strict dropping. Two-bit errors separate keeping from discarding after an error that cannot be repaired. Running the same corrupted cell in mode 00 shows that check bytes are not regenerated in that mode. A cell whose mode changes on every byte except the check byte shows when the mode is sampled. A run of bad cells drives a narrowed counter into saturation.

// File: rtl/hec_pkg.sv
package hec_pkg;

    localparam int HDR_BYTES = 5;
    localparam logic [7:0] HEC_COSET = 8'h55;
    localparam logic [7:0] HEC_POLY  = 8'h07;

    typedef enum logic [1:0] {
        MODE_PASS     = 2'b00,
        MODE_FIX_KEEP = 2'b01,
        MODE_STRICT   = 2'b10,
        MODE_FIX_DROP = 2'b11
    } chk_mode_e;

    typedef struct packed {
        logic       valid;
        logic       sop;
        logic [7:0] data;
    } lane_t;

    // Remainder of hdr * x^8 modulo the generator, bit 31 first.
    function automatic logic [7:0] crc8_hdr(input logic [31:0] hdr);
        logic [7:0] r;
        logic       fb;
        r = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            fb = r[7] ^ hdr[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ HEC_POLY;
        end
        return r;
    endfunction

    // Syndrome produced by a lone error on header bit pos.
    function automatic logic [7:0] bit_syndrome(input int pos);
        return crc8_hdr(32'(1) << pos);
    endfunction

endpackage

// File: rtl/hec_judge.sv
module hec_judge
    import hec_pkg::*;
(
    input  logic [31:0]                 hdr_rx,
    input  logic [7:0]                  hec_rx,
    input  logic [1:0]                  mode,
    output logic                        keep,
    output logic                        bump,
    output logic [HDR_BYTES-1:0][7:0]   hdr_out
);

    logic [7:0]  calc, syn, fix_hec;
    logic [31:0] hit;
    logic [31:0] fixed;
    logic        clean, hec_hit, fixable;
    logic [39:0] word;
    chk_mode_e   m;

    assign calc  = crc8_hdr(hdr_rx) ^ HEC_COSET;
    assign syn   = calc ^ hec_rx;
    assign clean = (syn == 8'h00);

    generate
        for (genvar j = 0; j < 32; j++) begin : g_match
            assign hit[j] = (syn == bit_syndrome(j));
        end
    endgenerate

    assign hec_hit = $onehot(syn);
    assign fixable = hec_hit | (|hit);
    assign fixed   = hdr_rx ^ hit;
    assign fix_hec = crc8_hdr(fixed) ^ HEC_COSET;
    assign m       = chk_mode_e'(mode);

    always_comb begin
        keep = 1'b1;
        bump = 1'b0;
        word = {hdr_rx, calc};
        unique case (m)
            MODE_PASS: begin
                word = {hdr_rx, hec_rx};
            end
            MODE_FIX_KEEP: begin
                if (clean || fixable) word = {fixed, fix_hec};
                else                  bump = 1'b1;
            end
            MODE_STRICT: begin
                keep = clean;
                bump = !clean;
            end
            MODE_FIX_DROP: begin
                if (clean || fixable) begin
                    word = {fixed, fix_hec};
                end else begin
                    keep = 1'b0;
                    bump = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        for (int k = 0; k < HDR_BYTES; k++)
            hdr_out[k] = word[39-8*k -: 8];
    end

endmodule

// File: rtl/hec_delay_line.sv
module hec_delay_line
    import hec_pkg::*;
#(
    parameter int DEPTH = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t lane_in,
    output lane_t lane_out
);

    lane_t stage [DEPTH+1];

    assign stage[0] = lane_in;

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[s+1] <= '0;
                else        stage[s+1] <= stage[s];
            end
        end
    endgenerate

    assign lane_out = stage[DEPTH];

endmodule

// File: rtl/hec_bad_counter.sv
module hec_bad_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      count <= '0;
        else if (inc && count != TOP)    count <= count + 1'b1;
    end

endmodule

// File: rtl/hec_out_seq.sv
module hec_out_seq
    import hec_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  lane_t                      tail,
    input  logic                       v_keep,
    input  logic [HDR_BYTES-1:0][7:0]  v_hdr,
    output logic                       out_valid,
    output logic                       out_sop,
    output logic [7:0]                 out_data,
    output logic                       drop_pulse
);

    localparam int PW = $clog2(CELL_BYTES);
    localparam int IW = $clog2(HDR_BYTES);
    localparam logic [PW-1:0] HDR_LAST  = PW'(HDR_BYTES - 1);
    localparam logic [PW-1:0] CELL_LAST = PW'(CELL_BYTES - 1);

    typedef enum logic [1:0] {OUT_IDLE, OUT_HDR, OUT_PAY, OUT_SKIP} out_state_e;

    out_state_e st_q, st_d;
    logic [PW-1:0] pos_q, pos_d;
    logic start, emit, sop_d, drop_d;
    logic [7:0] data_d;

    assign start = tail.valid & tail.sop;

    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        if (start) begin
            st_d  = v_keep ? OUT_HDR : OUT_SKIP;
            pos_d = PW'(1);
        end else if (tail.valid) begin
            unique case (st_q)
                OUT_IDLE: ;
                OUT_HDR: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_q == HDR_LAST) st_d = OUT_PAY;
                end
                OUT_PAY, OUT_SKIP: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_q == CELL_LAST) st_d = OUT_IDLE;
                end
                default: st_d = OUT_IDLE;
            endcase
        end
    end

    always_comb begin
        emit   = 1'b0;
        sop_d  = 1'b0;
        drop_d = 1'b0;
        data_d = tail.data;
        if (start) begin
            emit   = v_keep;
            sop_d  = v_keep;
            drop_d = !v_keep;
            data_d = v_hdr[0];
        end else if (tail.valid) begin
            emit = (st_q == OUT_HDR) || (st_q == OUT_PAY);
            if (st_q == OUT_HDR) data_d = v_hdr[pos_q[IW-1:0]];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= OUT_IDLE;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sop    <= 1'b0;
            out_data   <= 8'h00;
            drop_pulse <= 1'b0;
        end else begin
            out_valid  <= emit;
            out_sop    <= sop_d;
            out_data   <= emit ? data_d : 8'h00;
            drop_pulse <= drop_d;
        end
    end

endmodule

// File: rtl/cell_hec_filter.sv
module cell_hec_filter
    import hec_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic             out_sop,
    output logic [7:0]       out_data,
    output logic             drop_pulse,
    output logic [CNT_W-1:0] bad_hec_count
);

    localparam int PW = $clog2(CELL_BYTES);
    localparam logic [PW-1:0] HEC_POS  = PW'(HDR_BYTES - 1);
    localparam logic [PW-1:0] LAST_POS = PW'(CELL_BYTES - 1);

    typedef enum logic [1:0] {IN_IDLE, IN_HDR, IN_PAY} in_state_e;

    in_state_e st_q, st_d;
    logic [PW-1:0] pos_q, pos_d;
    logic start, decide;
    logic [HDR_BYTES-2:0][7:0] hq;
    logic j_keep, j_bump, v_keep;
    logic [HDR_BYTES-1:0][7:0] j_hdr, v_hdr;
    lane_t lane_in, tail;

    assign start = in_valid & in_sop;

    always_comb begin
        st_d   = st_q;
        pos_d  = pos_q;
        decide = 1'b0;
        if (start) begin
            st_d  = IN_HDR;
            pos_d = PW'(1);
        end else if (in_valid) begin
            unique case (st_q)
                IN_IDLE: ;
                IN_HDR: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_q == HEC_POS) begin
                        decide = 1'b1;
                        st_d   = IN_PAY;
                    end
                end
                IN_PAY: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_q == LAST_POS) st_d = IN_IDLE;
                end
                default: st_d = IN_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= IN_IDLE;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    // Header capture and verdict hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hq     <= '0;
            v_keep <= 1'b0;
            v_hdr  <= '0;
        end else begin
            if (start)
                hq[0] <= in_data;
            else if (in_valid && st_q == IN_HDR && pos_q != HEC_POS)
                hq[pos_q[1:0]] <= in_data;
            if (decide) begin
                v_keep <= j_keep;
                v_hdr  <= j_hdr;
            end
        end
    end

    hec_judge u_judge (
        .hdr_rx  ({hq[0], hq[1], hq[2], hq[3]}),
        .hec_rx  (in_data),
        .mode    (in_mode),
        .keep    (j_keep),
        .bump    (j_bump),
        .hdr_out (j_hdr)
    );

    hec_bad_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (decide & j_bump),
        .count (bad_hec_count)
    );

    assign lane_in = '{valid: in_valid, sop: start, data: in_data};

    hec_delay_line #(.DEPTH(HDR_BYTES)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_in  (lane_in),
        .lane_out (tail)
    );

    hec_out_seq #(.CELL_BYTES(CELL_BYTES)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .tail       (tail),
        .v_keep     (v_keep),
        .v_hdr      (v_hdr),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_data   (out_data),
        .drop_pulse (drop_pulse)
    );

endmodule

// File: rtl/hec_filter_chk.sv
module hec_filter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_sop,
    input logic             drop_pulse,
    input logic [CNT_W-1:0] bad_hec_count
);

    localparam logic [CNT_W-1:0] TOP = '1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (bad_hec_count == '0) && !out_valid);

    // R3
    sop_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    // R9
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> !out_valid);

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_hec_count != $past(bad_hec_count)) |->
            (bad_hec_count == $past(bad_hec_count) + 1'b1));

    // R10
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bad_hec_count) == TOP) |-> (bad_hec_count == TOP));

endmodule

bind cell_hec_filter hec_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_valid     (out_valid),
    .out_sop       (out_sop),
    .drop_pulse    (drop_pulse),
    .bad_hec_count (bad_hec_count)
);

// File: tb/cell_hec_filter_tb.sv
`timescale 1ns/1ps
module cell_hec_filter_tb;

    localparam int CELL = 53;
    localparam int CW   = 4;
    localparam logic [CW-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [1:0] in_mode = 2'b00;
    logic out_valid, out_sop, drop_pulse;
    logic [7:0] out_data;
    logic [CW-1:0] bad_hec_count;

    int n_vec = 0, n_bad = 0;
    int exp_drops = 0, got_drops = 0;
    int exp_cnt = 0;
    bit finished = 1'b0;
    logic [8:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    cell_hec_filter #(.CELL_BYTES(CELL), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .in_mode(in_mode), .out_valid(out_valid),
        .out_sop(out_sop), .out_data(out_data), .drop_pulse(drop_pulse),
        .bad_hec_count(bad_hec_count)
    );

    // Check byte by long division of the 40-bit word (R2)
    function automatic logic [7:0] ref_hec(input logic [31:0] h);
        logic [39:0] v;
        v = {h, 8'h00};
        for (int i = 39; i >= 8; i--)
            if (v[i]) v = v ^ (40'h107 << (i - 8));
        return v[7:0] ^ 8'h55;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Monitor: scoreboard compare
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (drop_pulse) got_drops++;
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected byte", {out_sop, out_data}, 9'h1ff);
                end else begin
                    automatic logic [8:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, {out_sop, out_data}, e);
                end
            end
        end
    end

    // Driver: md applies on the check byte, md_other on all others
    task automatic send_cell(input string tag, input logic [1:0] md,
                             input logic [1:0] md_other, input logic [31:0] hdr,
                             input logic [39:0] err, input int gap_every);
        logic [39:0] rx, outh;
        logic [7:0]  b;
        int nerr;
        bit keep, bump;
        rx   = {hdr, ref_hec(hdr)} ^ err;
        nerr = $countones(err);
        keep = 1'b1;
        bump = 1'b0;
        outh = {hdr, ref_hec(hdr)};
        case (md)
            2'b00: outh = rx;
            2'b01: begin
                bump = (nerr >= 2);
                if (nerr >= 2) outh = {rx[39:8], ref_hec(rx[39:8])};
            end
            2'b10: begin keep = (nerr == 0); bump = (nerr != 0); end
            default: begin keep = (nerr <= 1); bump = (nerr >= 2); end
        endcase
        if (bump && exp_cnt < int'(CMAX)) exp_cnt++;
        if (!keep) exp_drops++;
        for (int i = 0; i < CELL; i++) begin
            b = (i < 5) ? rx[39-8*i -: 8] : 8'(hdr[7:0] + 8'(i * 29));
            if (keep) begin
                exp_q.push_back({(i == 0), (i < 5) ? outh[39-8*i -: 8] : b});
                tag_q.push_back(tag);
            end
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_data  = b;
            in_mode  = (i == 4) ? md : md_other;
            @(negedge clk);
            if (gap_every > 0 && i >= 5 && (i % gap_every) == 0) begin
                in_valid = 1'b0;
                in_sop   = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 count in reset", bad_hec_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 count after reset", bad_hec_count, 0);

        // R11: stray bytes with no open cell
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_sop = 1'b0; in_data = 8'(8'hE0 + i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        drain();

        // R4: pass-through, even when corrupted
        send_cell("R4 clean", 2'b00, 2'b00, 32'h1234_5678, 40'h0, 0);
        send_cell("R4 corrupt", 2'b00, 2'b00, 32'h1234_5678, 40'h10_0000_0001, 0);
        drain();
        check("R4 count unchanged", bad_hec_count, exp_cnt);

        // R2 and R5
        send_cell("R2 zero header", 2'b01, 2'b01, 32'h0, 40'h0, 0);
        send_cell("R5 header bit", 2'b01, 2'b01, 32'hA5C3_0F10, 40'h20_0000_0000, 0);
        send_cell("R5 check-byte bit", 2'b01, 2'b01, 32'h0BAD_F00D, 40'h4, 0);
        drain();
        check("R5 count unchanged", bad_hec_count, 0);

        // R6
        send_cell("R6 double error kept", 2'b01, 2'b01, 32'h7766_5544, 40'h00_0100_8000, 0);
        drain();
        check("R6 count", bad_hec_count, 1);

        // R7
        send_cell("R7 clean kept", 2'b10, 2'b10, 32'h3141_5926, 40'h0, 0);
        send_cell("R7 single dropped", 2'b10, 2'b10, 32'h3141_5926, 40'h00_0000_0100, 0);
        send_cell("R7 double dropped", 2'b10, 2'b10, 32'h2718_2818, 40'h01_0000_0001, 0);
        drain();
        check("R7 count", bad_hec_count, 3);

        // R8
        send_cell("R8 single repaired", 2'b11, 2'b11, 32'hDEAD_BEEF, 40'h00_8000_0000, 0);
        send_cell("R8 double dropped", 2'b11, 2'b11, 32'hDEAD_BEEF, 40'h00_0003_0000, 0);
        drain();
        check("R8 count", bad_hec_count, 4);

        // R3: payload gaps
        send_cell("R3 gapped payload", 2'b01, 2'b01, 32'h0F1E_2D3C, 40'h0, 7);
        // R12: strict mode only on the check byte, pass elsewhere
        send_cell("R12 late mode", 2'b10, 2'b00, 32'h5A5A_0001, 40'h00_0000_0200, 0);
        drain();
        check("R12 count", bad_hec_count, 5);

        // R10: saturation
        for (int k = 0; k < 12; k++)
            send_cell("R10 filler", 2'b10, 2'b10, 32'(32'h0100_0000 + k), 40'h80, 0);
        drain();
        check("R10 saturated count", bad_hec_count, int'(CMAX));
        check("R10 model count", exp_cnt, int'(CMAX));

        check("R9 drop pulses", got_drops, exp_drops);
        check("R3 all bytes seen", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule